// File: doc/BRIEF.md
# I2C Bus Recovery and Chain-Type Probe Sequencer

This block owns an open-drain clock/data pair and, on request, first frees a bus that a device may be holding low, then works out which board wiring is fitted by probing a short list of device addresses. A line goes low only when its output enable is asserted, and goes high only when the enable is removed so that the pull-up takes it. One line action is performed per pulse of a quarter-bit timing tick. The data line is read back through a small synchronizer.

A request is a one-cycle pulse on `start_i`. The block remembers which candidate answered. A later request with a remembered result returns at once, with no bus traffic. If no candidate answers, the request ends in failure and nothing is remembered, so the next request probes the bus again.

Top module: `i2c_recover_probe`

## Requirements
- R1: `scl_oe_o`/`sda_oe_o` high means the line is pulled low, and low means it is released. After reset both are 0 and `done_o`, `fail_o` and `chain_o` are 0. Whenever `done_o` is high, both lines are released.
- R2: Each `tick_i` pulse performs at most one line action. An output enable changes only in the cycle after a tick, and the two enables never change in the same cycle.
- R3: Recovery pulls SCL low, releases SDA, then gives at most RECOV_MAX (9) SCL pulses. SDA is sampled while SCL is high in each pulse.
- R4: On the first pulse in which SDA reads high, the block pulls SDA low with SCL high (START). It then pulls SCL low, releases SCL, and releases SDA (STOP). No further recovery pulses follow.
- R5: If SDA reads low in all 9 pulses, recovery ends by releasing SCL, and that candidate counts as not answering.
- R6: After a successful recovery, a probe sends START and then the byte (candidate address with bit 0 forced to 1), most significant bit first. SDA is released for a ninth clock and sampled while SCL is high. Low means acknowledged.
- R7: On acknowledge the probe gives 8 more SCL pulses with SDA released (a discarded byte read) before STOP. On no acknowledge it sends STOP at once.
- R8: Candidates are tried in table order 0xA4, 0xA0, 0xA2, and the table ends at the sentinel 0xFF. The first candidate to acknowledge sets `chain_o` to its index plus 1 (1, 2 or 3). The value 0 means not yet determined.
- R9: When candidate 0 (0xA4) is selected, one extra recovery (START then STOP) is run before `done_o`.
- R10: If no candidate acknowledges, `done_o` and `fail_o` pulse together and `chain_o` stays 0. A later request probes all candidates again.
- R11: A request made while `chain_o` is nonzero gives no bus activity. `done_o` then pulses in the cycle after `start_i` is sampled, with `fail_o` low.
- R12: `done_o` is high for exactly one cycle per request, and `start_i` has no effect while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse |
| tick_i | input | 1 | Quarter-bit timing pulse; one line action per pulse |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe_o | output | 1 | Clock line pull-down enable |
| sda_oe_o | output | 1 | Data line pull-down enable |
| done_o | output | 1 | One-cycle end-of-request pulse |
| fail_o | output | 1 | With `done_o`: no candidate answered |
| chain_o | output | 3 | Remembered candidate index plus 1; 0 = unknown |

## Verification
The bench uses the default build: a four-entry table of three candidates plus the sentinel, a nine-pulse recovery limit, a two-stage synchronizer and a tick every fourth clock. With these values it can sweep every candidate position, plus the case where no device answers, against a device that holds SDA low for 0, 1, 4 or 9 clock pulses or for ever. For each run, the expected number of SCL pulses, START conditions and address bytes is computed from the step counts in the requirements.

// File: rtl/i2crp_pkg.sv
`timescale 1ns/1ps
// Shared types for the bus recovery / probe sequencer.
// Assumes: one line action per tick, actions encoded as below.
package i2crp_pkg;

    // Single line action applied on a tick
    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_SCL_PULL = 3'd1,
        CMD_SCL_FREE = 3'd2,
        CMD_SDA_PULL = 3'd3,
        CMD_SDA_FREE = 3'd4
    } line_cmd_t;

    // Sequencer steps; each tick-paced step issues one line action
    typedef enum logic [4:0] {
        S_IDLE,
        S_RC_SCLLO, S_RC_SDAREL, S_RC_HI, S_RC_SMP, S_RC_LO, S_RC_GIVEUP,
        S_RC_STA, S_RC_SCLDN, S_RC_SCLUP, S_RC_STO,
        S_ST_SDA, S_ST_SCL, S_ST_DROP, S_ST_LOW,
        S_WB_BIT, S_WB_HI, S_WB_LO,
        S_AK_REL, S_AK_HI, S_AK_SMP, S_AK_LO,
        S_RB_HI, S_RB_SMP, S_RB_LO,
        S_SP_SCL, S_SP_SDA, S_SP_HI, S_SP_REL,
        S_NEXT,
        S_FIN
    } seq_state_t;

endpackage

// File: rtl/i2crp_sync.sv
`timescale 1ns/1ps
// Synchronizer for the incoming data line.
// Assumes: idle bus level is high, so every stage resets to 1.
module i2crp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_q;
            // Shift the line sample through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2+1-1:0], d_i};
            end
            assign q_o = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2crp_cand_table.sv
`timescale 1ns/1ps
// Candidate address table lookup with end detection.
// Assumes: entry g sits in TABLE[8*g +: 8]; an entry equal to SENTINEL or
// an index past the table marks the end of the list.
module i2crp_cand_table #(
    parameter int           N_ENT    = 4,
    parameter logic [N_ENT*8-1:0] TABLE = 32'hFF_A2_A0_A4,
    parameter logic [7:0]   SENTINEL = 8'hFF,
    parameter int           IDX_W    = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       addr_o,
    output logic             end_o
);
    logic [7:0] ent [N_ENT];

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_ent
            assign ent[g] = TABLE[8*g +: 8];
        end
    endgenerate

    // Select the entry for the current index; out of range reads as end
    always_comb begin
        addr_o = SENTINEL;
        for (int i = 0; i < N_ENT; i++) begin
            if (idx_i == IDX_W'(i)) addr_o = ent[i];
        end
    end

    assign end_o = (addr_o == SENTINEL);
endmodule

// File: rtl/i2crp_lines.sv
`timescale 1ns/1ps
// Open-drain line enables: holds the pull-down enable for each line and
// applies one action per tick. Enable 1 = line pulled low, 0 = released.
module i2crp_lines
    import i2crp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  line_cmd_t cmd_i,
    output logic      scl_oe_o,
    output logic      sda_oe_o
);
    // Apply the requested line action on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_oe_o <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (tick_i) begin
            case (cmd_i)
                CMD_SCL_PULL: scl_oe_o <= 1'b1;
                CMD_SCL_FREE: scl_oe_o <= 1'b0;
                CMD_SDA_PULL: sda_oe_o <= 1'b1;
                CMD_SDA_FREE: sda_oe_o <= 1'b0;
                default:      ;
            endcase
        end
    end

    // R2
    scl_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_oe_o) |-> $past(tick_i));
    // R2
    sda_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(tick_i));
    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(scl_oe_o) && !$stable(sda_oe_o)));
endmodule

// File: rtl/i2crp_seq.sv
`timescale 1ns/1ps
// Recovery / probe step sequencer. Walks the candidate table, running a
// recovery and an address probe per entry, remembers the winner as
// index+1, and re-runs recovery once after the legacy (index 0) entry.
// Assumes: sda_s_i is already synchronized; tick period exceeds the
// synchronizer depth so a sample reflects the previous line action.
module i2crp_seq
    import i2crp_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int RECOV_MAX = 9,
    localparam int RCNT_W   = $clog2(RECOV_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             sda_s_i,
    input  logic [7:0]       cand_addr_i,
    input  logic             cand_end_i,
    output logic [IDX_W-1:0] idx_o,
    output line_cmd_t        cmd_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [IDX_W-1:0] chain_o
);
    localparam logic [IDX_W-1:0] LEGACY_IDX = '0;

    seq_state_t        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  chain_q;
    logic [RCNT_W-1:0] rcnt_q;
    logic [2:0]        bit_q;
    logic              acked_q;
    logic              extra_q;
    logic              fail_q;
    logic [7:0]        probe_byte;

    assign probe_byte = cand_addr_i | 8'h01;

    // Line action for the current step
    always_comb begin
        case (st_q)
            S_RC_SCLLO, S_RC_LO, S_RC_SCLDN,
            S_ST_LOW, S_WB_LO, S_AK_LO, S_RB_LO, S_SP_SCL: cmd_o = CMD_SCL_PULL;
            S_RC_HI, S_RC_GIVEUP, S_RC_SCLUP, S_ST_SCL,
            S_WB_HI, S_AK_HI, S_RB_HI, S_SP_HI:            cmd_o = CMD_SCL_FREE;
            S_RC_STA, S_ST_DROP, S_SP_SDA:                 cmd_o = CMD_SDA_PULL;
            S_RC_SDAREL, S_RC_STO, S_ST_SDA,
            S_AK_REL, S_SP_REL:                            cmd_o = CMD_SDA_FREE;
            S_WB_BIT: cmd_o = probe_byte[bit_q] ? CMD_SDA_FREE : CMD_SDA_PULL;
            default:                                       cmd_o = CMD_NONE;
        endcase
    end

    // Step sequencing: idle/next/finish act at once, all others on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            idx_q   <= '0;
            chain_q <= '0;
            rcnt_q  <= '0;
            bit_q   <= '0;
            acked_q <= 1'b0;
            extra_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (start_i) begin
                    fail_q  <= 1'b0;
                    extra_q <= 1'b0;
                    idx_q   <= '0;
                    st_q    <= (chain_q != '0) ? S_FIN : S_RC_SCLLO;
                end
                S_NEXT: begin
                    if (cand_end_i) begin
                        fail_q <= 1'b1;
                        st_q   <= S_FIN;
                    end else begin
                        st_q   <= S_RC_SCLLO;
                    end
                end
                S_FIN: st_q <= S_IDLE;
                default: if (tick_i) begin
                    case (st_q)
                        S_RC_SCLLO:  st_q <= S_RC_SDAREL;
                        S_RC_SDAREL: begin rcnt_q <= '0; st_q <= S_RC_HI; end
                        S_RC_HI:     st_q <= S_RC_SMP;
                        S_RC_SMP:    st_q <= sda_s_i ? S_RC_STA : S_RC_LO;
                        S_RC_LO: begin
                            if (rcnt_q == RCNT_W'(RECOV_MAX - 1)) st_q <= S_RC_GIVEUP;
                            else begin rcnt_q <= rcnt_q + 1'b1; st_q <= S_RC_HI; end
                        end
                        S_RC_GIVEUP: begin
                            if (extra_q) st_q <= S_FIN;
                            else begin idx_q <= idx_q + 1'b1; st_q <= S_NEXT; end
                        end
                        S_RC_STA:    st_q <= S_RC_SCLDN;
                        S_RC_SCLDN:  st_q <= S_RC_SCLUP;
                        S_RC_SCLUP:  st_q <= S_RC_STO;
                        S_RC_STO:    st_q <= extra_q ? S_FIN : S_ST_SDA;
                        S_ST_SDA:    st_q <= S_ST_SCL;
                        S_ST_SCL:    st_q <= S_ST_DROP;
                        S_ST_DROP:   st_q <= S_ST_LOW;
                        S_ST_LOW:    begin bit_q <= 3'd7; st_q <= S_WB_BIT; end
                        S_WB_BIT:    st_q <= S_WB_HI;
                        S_WB_HI:     st_q <= S_WB_LO;
                        S_WB_LO: begin
                            if (bit_q == 3'd0) st_q <= S_AK_REL;
                            else begin bit_q <= bit_q - 1'b1; st_q <= S_WB_BIT; end
                        end
                        S_AK_REL:    st_q <= S_AK_HI;
                        S_AK_HI:     st_q <= S_AK_SMP;
                        S_AK_SMP:    begin acked_q <= !sda_s_i; st_q <= S_AK_LO; end
                        S_AK_LO: begin
                            bit_q <= 3'd7;
                            st_q  <= acked_q ? S_RB_HI : S_SP_SCL;
                        end
                        S_RB_HI:     st_q <= S_RB_SMP;
                        S_RB_SMP:    st_q <= S_RB_LO;
                        S_RB_LO: begin
                            if (bit_q == 3'd0) st_q <= S_SP_SCL;
                            else begin bit_q <= bit_q - 1'b1; st_q <= S_RB_HI; end
                        end
                        S_SP_SCL:    st_q <= S_SP_SDA;
                        S_SP_SDA:    st_q <= S_SP_HI;
                        S_SP_HI:     st_q <= S_SP_REL;
                        S_SP_REL: begin
                            if (acked_q) begin
                                chain_q <= idx_q + 1'b1;
                                if (idx_q == LEGACY_IDX) begin
                                    extra_q <= 1'b1;
                                    st_q    <= S_RC_SCLLO;
                                end else begin
                                    st_q    <= S_FIN;
                                end
                            end else begin
                                idx_q <= idx_q + 1'b1;
                                st_q  <= S_NEXT;
                            end
                        end
                        default:     st_q <= S_IDLE;
                    endcase
                end
            endcase
        end
    end

    assign idx_o   = idx_q;
    assign chain_o = chain_q;
    assign done_o  = (st_q == S_FIN);
    assign fail_o  = (st_q == S_FIN) && fail_q;

    // R8
    chain_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_q != $past(chain_q)) |-> ($past(chain_q) == '0));
    // R10
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (chain_q == '0));
    // R3
    recov_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt_q < RCNT_W'(RECOV_MAX));
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/i2c_recover_probe.sv
`timescale 1ns/1ps
// Top: bus recovery and chain-type probe sequencer on an open-drain pair.
// Assumes: tick_i pulses no more often than every SYNC_STAGES+2 clocks;
// no clock stretching and a single master on the bus.
module i2c_recover_probe
    import i2crp_pkg::*;
#(
    parameter int                 N_ENT       = 4,
    parameter logic [N_ENT*8-1:0] CAND_TABLE  = 32'hFF_A2_A0_A4,
    parameter int                 RECOV_MAX   = 9,
    parameter int                 SYNC_STAGES = 2,
    localparam int                IDX_W       = $clog2(N_ENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [IDX_W-1:0] chain_o
);
    logic             sda_s;
    logic [IDX_W-1:0] idx;
    logic [7:0]       cand_addr;
    logic             cand_end;
    line_cmd_t        cmd;

    i2crp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2crp_cand_table #(
        .N_ENT(N_ENT), .TABLE(CAND_TABLE), .SENTINEL(8'hFF), .IDX_W(IDX_W)
    ) u_table (
        .idx_i(idx), .addr_o(cand_addr), .end_o(cand_end)
    );

    i2crp_seq #(.IDX_W(IDX_W), .RECOV_MAX(RECOV_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
        .sda_s_i(sda_s), .cand_addr_i(cand_addr), .cand_end_i(cand_end),
        .idx_o(idx), .cmd_o(cmd), .done_o(done_o), .fail_o(fail_o),
        .chain_o(chain_o)
    );

    i2crp_lines u_lines (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmd_i(cmd),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
    );

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scl_oe_o && !sda_oe_o));
    // R10
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);
endmodule

// File: tb/sim_i2c_recover_probe.sv
`timescale 1ns/1ps
module sim_i2c_recover_probe;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic       scl_oe, sda_oe, done, fail;
    logic [2:0] chain;
    logic       slv_pull = 1'b0;
    wire        scl_w = ~scl_oe;
    wire        sda_w = ~(sda_oe | slv_pull);

    always #2 clk = ~clk;

    i2c_recover_probe u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .done_o(done), .fail_o(fail), .chain_o(chain)
    );

    localparam logic [7:0] DATA = 8'h5A;
    int checks = 0, failures = 0;
    int stuck_n = 0, hold_rises = 0, rise_cnt = 0, start_cnt = 0;
    int nbits = 0, nlog = 0, mode = 0, done_cnt = 0, pace_err = 0, div = 0;
    logic [7:0] my_addr = 8'h30, shreg = 8'h00;
    logic [7:0] alog [0:7];
    logic pscl = 1'b1, psda = 1'b1, dbit = 1'b1, pscl_oe = 1'b0, psda_oe = 1'b0;

    function automatic logic [7:0] cand(input int i);
        case (i)
            0: return 8'hA4;
            1: return 8'hA0;
            default: return 8'hA2;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Bus device model, pace monitor and tick generator (negedge only)
    always @(negedge clk) begin
        logic r, f;
        r = scl_w && !pscl;
        f = !scl_w && pscl;
        if (r) begin rise_cnt++; hold_rises++; end
        if (scl_w && pscl && psda && !sda_w) begin
            start_cnt++; mode = 1; nbits = 0;
        end else if (scl_w && pscl && !psda && sda_w) begin
            mode = 0;
        end else begin
            case (mode)
                1: if (r) begin shreg = {shreg[6:0], sda_w}; nbits++; end
                   else if (f && nbits == 8) begin
                       if (nlog < 8) alog[nlog] = shreg;
                       nlog++;
                       mode = (shreg[7:1] == my_addr[7:1]) ? 2 : 0;
                   end
                2: if (f) begin
                       if (shreg[0]) begin mode = 3; nbits = 0; dbit = DATA[7]; end
                       else mode = 0;
                   end
                3: if (r) nbits++;
                   else if (f) begin
                       if (nbits >= 8) mode = 0;
                       else dbit = DATA[7 - nbits];
                   end
                default: ;
            endcase
        end
        slv_pull = (hold_rises < stuck_n) || (mode == 2) || (mode == 3 && !dbit);
        pscl = scl_w;
        psda = sda_w;
        if (rst_n) begin
            if ((scl_oe != pscl_oe || sda_oe != psda_oe) && !tick) pace_err++;
            if (scl_oe != pscl_oe && sda_oe != psda_oe) pace_err++;
        end
        pscl_oe = scl_oe;
        psda_oe = sda_oe;
        if (done) done_cnt++;
        tick = (div == 3);
        div = (div + 1) % 4;
    end

    task automatic cfg(input int k, input int stuck);
        @(posedge clk);
        my_addr = (k >= 0 && k <= 2) ? cand(k) : 8'h30;
        stuck_n = stuck; hold_rises = 0; mode = 0; nlog = 0;
        rise_cnt = 0; start_cnt = 0; done_cnt = 0;
        slv_pull = (stuck > 0);
        psda = !(stuck > 0) && !sda_oe;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int n;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        ok = done;
        if (!ok) chk(1'b0, "R12 watchdog on done", 0, 1);
    endtask

    // Expected bus activity computed from the step counts of R3..R9
    task automatic expect_of(input int k, input int stuck, output int er, output int es,
                             output int enl, output bit ef);
        int p;
        er = 0; es = 0; enl = 0; ef = 1'b1;
        p = (stuck == 0) ? 1 : stuck;
        if (stuck > 9) begin er = 30; return; end
        for (int i = 0; i < 3; i++) begin
            int pp;
            pp = (i == 0) ? p : 1;
            enl++;
            es += 2;
            if (i == k) begin
                er += pp + 19;
                if (k == 0) begin er += 2; es += 1; end
                ef = 1'b0;
                return;
            end
            er += pp + 11;
        end
    endtask

    task automatic run_case(input int k, input int stuck, input bit reset_first, input bit poke);
        int er, es, enl; bit ef, ok;
        if (reset_first) do_reset();
        cfg(k, stuck);
        expect_of(k, stuck, er, es, enl, ef);
        pulse_start();
        if (poke) begin
            repeat (200) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        wait_done(ok);
        if (!ok) return;
        chk(fail == ef, "R10 fail flag", fail, ef);
        chk(chain == (ef ? 3'd0 : 3'(k + 1)), "R8 chain index+1", chain, ef ? 0 : k + 1);
        chk(rise_cnt == er, "R3/R4/R5/R7 SCL pulse count", rise_cnt, er);
        chk(start_cnt == es, "R4/R6/R9 START count", start_cnt, es);
        chk(nlog == enl, "R8 probes made", nlog, enl);
        for (int i = 0; i < 3; i++) begin
            if (i < enl) chk(alog[i] == (cand(i) | 8'h01), "R6 probe byte order", alog[i], cand(i) | 8'h01);
        end
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1 lines released at done", {scl_oe, sda_oe}, 0);
        repeat (30) @(negedge clk);
        chk(done_cnt == 1, "R12 single done pulse", done_cnt, 1);
        if (k == 0 && !ef)
            chk(rise_cnt == er && start_cnt == es, "R9 extra recovery after legacy", start_cnt, es);
    endtask

    initial begin
        #(4 * 180000);
        checks++; failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit ok;
        int snap;
        do_reset();
        @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R1 reset lines", {scl_oe, sda_oe}, 0);
        chk(done == 0 && fail == 0, "R1 reset flags", {done, fail}, 0);
        chk(chain == 0, "R1 reset chain", chain, 0);

        // Sweep: device position x stuck depth
        for (int k = 0; k <= 3; k++) begin
            for (int s = 0; s < 4; s++) begin
                int st;
                st = (s == 0) ? 0 : (s == 1) ? 1 : (s == 2) ? 4 : 9;
                run_case(k, st, 1'b1, 1'b0);
            end
        end

        // R5: data line never released
        run_case(1, 1000, 1'b1, 1'b0);

        // R10: failed result is not remembered; second request probes again
        run_case(3, 0, 1'b1, 1'b0);
        run_case(3, 0, 1'b0, 1'b0);

        // R12: start during a run is ignored
        run_case(2, 0, 1'b1, 1'b1);

        // R11: remembered result answers immediately with no bus traffic
        snap = rise_cnt;
        cfg(2, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b1, "R11 done in cycle after start", done, 1);
        chk(fail == 1'b0, "R11 fail low", fail, 0);
        repeat (40) @(negedge clk);
        chk(rise_cnt == 0 && start_cnt == 0, "R11 no bus activity", rise_cnt + start_cnt, 0);
        chk(chain == 3'd3, "R11 chain kept", chain, 3);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);
        if (snap < 0) ok = 1'b0;

        chk(pace_err == 0, "R2 line pacing", pace_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule